// File: doc/BRIEF.md
# Bunch-Train Pixel Timestamp Recorder

This block captures hit times for a single pixel during an accelerator bunch train. A pulse on the train-start input opens a window of 5000 bunch crossings. A crossing strobe advances a crossing counter. When the comparator bit is high on a strobe, the current crossing number is written as a 13-bit timestamp into a 16-entry local store. Once the last crossing has been taken, the block sends a serial frame during the gap between trains. The frame holds the hit count, the timestamps in the order they were captured, and an overflow bit.

The comparator enable output is high only while the window is open, so the front end can be powered down between trains. A pixel mask is loaded beforehand as configuration. A masked pixel captures nothing and sends no frame. Every readout must finish before the next train starts. If a train start arrives while a frame is still being sent, the frame is cut off, the store is emptied for the new train, and an error flag is raised.

Top module: `pixel_ts_recorder`

## Requirements
- R1: While reset is held and on the first cycle after it, comp_en_o, ser_valid_o, ser_o, overflow_o and abort_o are all low.
- R2: comp_en_o goes high on the cycle after a train_start_i pulse. It stays high until the edge that takes the 5000th crossing strobe of that train, and is low otherwise.
- R3: A strobe with hit_i high during the window stores the number of strobes seen earlier in the same train as its timestamp. The first crossing is 0 and the last is 4999. A hit or strobe outside the window stores nothing.
- R4: At most 16 timestamps are kept per train, and later hits are dropped. overflow_o goes high on the first dropped hit, stays high through readout and is cleared by the next train_start_i.
- R5: The frame begins on the cycle after the edge that takes the final crossing. ser_valid_o is high for exactly 5 + 13·n + 1 consecutive cycles, with one bit per cycle on ser_o. The bits are: the 5-bit stored count n, most significant bit first; then each 13-bit timestamp, most significant bit first, oldest first; then the overflow bit.
- R6: While the mask bit (loaded through mask_we_i and mask_i, where 1 means masked) is set, hits are ignored, no frame is sent and overflow_o stays low.
- R7: A train_start_i while ser_valid_o is high ends the frame. ser_valid_o is low on the next cycle and abort_o goes high. abort_o stays high until a later train_start_i that arrives with no readout running. The new train's frame holds only the new train's hits.
- R8: Strobes and hits during readout do not change the frame being sent.
- R9: The counter advances on strobes, not on clock cycles. Idle cycles between strobes do not change the timestamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for capture and readout |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_start_i | input | 1 | One-cycle pulse that opens a new train |
| xing_i | input | 1 | Bunch-crossing strobe |
| hit_i | input | 1 | Comparator output, sampled with xing_i |
| mask_we_i | input | 1 | Loads mask_i into the mask register |
| mask_i | input | 1 | Mask value, 1 = pixel masked |
| comp_en_o | output | 1 | Comparator enable, high while the train window is open |
| ser_o | output | 1 | Serial frame data |
| ser_valid_o | output | 1 | High while ser_o carries a frame bit |
| overflow_o | output | 1 | Sticky flag: at least one hit was dropped in this train |
| abort_o | output | 1 | The previous readout was cut off by a train start |

## Verification
The bench checks capture with hit patterns that tell different failure modes apart:
- Hits at crossing 0, crossing 4999 and in between show off-by-one errors at both ends of the window.
- Back-to-back hits with idle cycles between strobes distinguish a strobe counter from a cycle counter.
- An empty train confirms the minimal six-bit frame.
- Twenty hits show that the first sixteen are kept in order and that overflow is set.

Strobes and hits sent outside the window and during readout must leave the frame unchanged. A masked train must produce no frame. Cutting a frame off partway must set the abort flag and must not leak earlier hits into the next frame.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    FLD_IDLE = 2'd0,
    FLD_HDR  = 2'd1,
    FLD_TS   = 2'd2,
    FLD_OVF  = 2'd3
  } fld_e;
endpackage

// File: rtl/pts_xing_ctr.sv
module pts_xing_ctr #(
  parameter int N_XING = 5000,
  parameter int TS_W   = $clog2(N_XING)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            train_start_i,
  input  logic            xing_i,
  output logic            in_train_o,
  output logic [TS_W-1:0] cnt_o,
  output logic            last_o
);
  localparam logic [TS_W-1:0] LAST = TS_W'(N_XING - 1);

  logic            in_train_q;
  logic [TS_W-1:0] cnt_q;

  assign last_o     = in_train_q && xing_i && (cnt_q == LAST);
  assign in_train_o = in_train_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_train_q <= 1'b0;
      cnt_q      <= '0;
    end else if (train_start_i) begin
      in_train_q <= 1'b1;
      cnt_q      <= '0;
    end else if (in_train_q && xing_i) begin
      if (last_o) in_train_q <= 1'b0;
      else        cnt_q      <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_train_q |-> cnt_q <= LAST);
  // counter moves only on a strobe
  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xing_i && !train_start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pts_ts_store.sv
module pts_ts_store #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 13,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] wptr_q;
  logic             ovf_q;
  logic [TS_W-1:0]  mem_q [DEPTH];
  logic             full;

  assign full    = (wptr_q == FULL);
  assign count_o = wptr_q;
  assign ovf_o   = ovf_q;
  assign rd_ts_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clear_i) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else if (wr_i) begin
      if (full) ovf_q  <= 1'b1;
      else      wptr_q <= wptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (wr_i && !clear_i && !full && (wptr_q == CNT_W'(g)))
        mem_q[g] <= ts_i;
    end
  end

  assert_wptr_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= FULL);
  assert_ovf_only_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> full);
endmodule

// File: rtl/pts_serializer.sv
module pts_serializer
  import pts_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TS_W  = 13,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int BIT_W = $clog2((TS_W > CNT_W) ? TS_W : CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ovf_i,
  input  logic [TS_W-1:0]  rd_ts_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             ser_o,
  output logic             valid_o
);
  fld_e             fld_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] slot_q;
  logic             last_slot;

  assign rd_idx_o  = slot_q;
  assign valid_o   = (fld_q != FLD_IDLE);
  assign last_slot = ((CNT_W'(slot_q) + CNT_W'(1)) == count_i);

  always_comb begin
    unique case (fld_q)
      FLD_HDR: ser_o = count_i[bit_q];
      FLD_TS:  ser_o = rd_ts_i[bit_q];
      FLD_OVF: ser_o = ovf_i;
      default: ser_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q  <= FLD_IDLE;
      bit_q  <= '0;
      slot_q <= '0;
    end else if (abort_i) begin
      fld_q <= FLD_IDLE;
    end else if (start_i) begin
      fld_q  <= FLD_HDR;
      bit_q  <= BIT_W'(CNT_W - 1);
      slot_q <= '0;
    end else begin
      unique case (fld_q)
        FLD_HDR: begin
          if (bit_q != '0) bit_q <= bit_q - 1'b1;
          else if (count_i == '0) fld_q <= FLD_OVF;
          else begin
            fld_q <= FLD_TS;
            bit_q <= BIT_W'(TS_W - 1);
          end
        end
        FLD_TS: begin
          if (bit_q != '0) bit_q <= bit_q - 1'b1;
          else if (last_slot) fld_q <= FLD_OVF;
          else begin
            slot_q <= slot_q + 1'b1;
            bit_q  <= BIT_W'(TS_W - 1);
          end
        end
        FLD_OVF: fld_q <= FLD_IDLE;
        default: fld_q <= FLD_IDLE;
      endcase
    end
  end

  assert_frame_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (valid_o && fld_q == FLD_HDR));
  assert_slot_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_q == FLD_TS) |-> (CNT_W'(slot_q) < count_i));
endmodule

// File: rtl/pixel_ts_recorder.sv
module pixel_ts_recorder #(
  parameter int N_XING = 5000,
  parameter int DEPTH  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic train_start_i,
  input  logic xing_i,
  input  logic hit_i,
  input  logic mask_we_i,
  input  logic mask_i,
  output logic comp_en_o,
  output logic ser_o,
  output logic ser_valid_o,
  output logic overflow_o,
  output logic abort_o
);
  localparam int TS_W  = $clog2(N_XING);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             in_train, last_xing, wr, rd_start;
  logic             mask_q, abort_q, ovf;
  logic [TS_W-1:0]  cnt, rd_ts;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] count;

  pts_xing_ctr #(.N_XING(N_XING), .TS_W(TS_W)) i_ctr (
    .clk_i, .rst_ni, .train_start_i, .xing_i,
    .in_train_o(in_train), .cnt_o(cnt), .last_o(last_xing)
  );

  assign wr       = in_train && xing_i && hit_i && !mask_q;
  assign rd_start = last_xing && !mask_q;

  pts_ts_store #(.DEPTH(DEPTH), .TS_W(TS_W)) i_store (
    .clk_i, .rst_ni, .clear_i(train_start_i), .wr_i(wr), .ts_i(cnt),
    .rd_idx_i(rd_idx), .rd_ts_o(rd_ts), .count_o(count), .ovf_o(ovf)
  );

  pts_serializer #(.DEPTH(DEPTH), .TS_W(TS_W)) i_ser (
    .clk_i, .rst_ni, .start_i(rd_start), .abort_i(train_start_i),
    .count_i(count), .ovf_i(ovf), .rd_ts_i(rd_ts), .rd_idx_o(rd_idx),
    .ser_o, .valid_o(ser_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (mask_we_i)     mask_q  <= mask_i;
      if (train_start_i) abort_q <= ser_valid_o;
    end
  end

  assign comp_en_o  = in_train;
  assign overflow_o = ovf;
  assign abort_o    = abort_q;

  assert_no_read_in_train_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> !comp_en_o);
  assert_abort_cut_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_start_i && ser_valid_o) |=> (abort_o && !ser_valid_o));
  assert_masked_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !mask_we_i && !ser_valid_o) |=> !ser_valid_o);
  assert_masked_no_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !mask_we_i && !overflow_o) |=> !overflow_o);
endmodule

// File: tb/test_pixel_ts_recorder.sv
module test_pixel_ts_recorder;
  localparam int NX = 5000;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic train_start_i = 0, xing_i = 0, hit_i = 0, mask_we_i = 0, mask_i = 0;
  logic comp_en_o, ser_o, ser_valid_o, overflow_o, abort_o;

  int n_chk = 0, n_bad = 0;
  bit frame_q[$];
  int hits_q[$];
  bit hm [int];

  always #4 clk = ~clk;

  pixel_ts_recorder #(.N_XING(NX), .DEPTH(DP)) i_pixel_ts_recorder (
    .clk_i(clk), .rst_ni, .train_start_i, .xing_i, .hit_i, .mask_we_i, .mask_i,
    .comp_en_o, .ser_o, .ser_valid_o, .overflow_o, .abort_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_hits(input int h[$]);
    hits_q = h;
    hm.delete();
    foreach (h[i]) hm[h[i]] = 1'b1;
  endtask

  // pulse start, then NX strobes with gap idle cycles between; returns right after final edge
  task automatic run_train(input int gap);
    @(negedge clk) train_start_i = 1;
    @(negedge clk) train_start_i = 0;
    check(comp_en_o == 1'b1, "R2 comp_en after start", comp_en_o, 1);
    for (int k = 0; k < NX; k++) begin
      xing_i = 1; hit_i = hm.exists(k);
      @(negedge clk);
      xing_i = 0; hit_i = 0;
      if (k == NX - 2) check(comp_en_o == 1'b1, "R2 comp_en before last", comp_en_o, 1);
      if (k != NX - 1) repeat (gap) @(negedge clk);
    end
    check(comp_en_o == 1'b0, "R2 comp_en after last", comp_en_o, 0);
  endtask

  task automatic collect(input bit noise);
    int guard = 0;
    frame_q.delete();
    while (ser_valid_o && guard < 1000) begin
      frame_q.push_back(ser_o);
      xing_i = noise; hit_i = noise;
      @(negedge clk);
      guard++;
    end
    xing_i = 0; hit_i = 0;
  endtask

  function automatic int field(input int pos, input int w);
    int v = 0;
    for (int b = 0; b < w; b++) v = (v << 1) | int'(frame_q[pos + b]);
    return v;
  endfunction

  task automatic verify_frame(input string req);
    int n = (hits_q.size() > DP) ? DP : hits_q.size();
    int eo = (hits_q.size() > DP) ? 1 : 0;
    int len = 5 + 13 * n + 1;
    check(frame_q.size() == len, {req, " frame length"}, frame_q.size(), len);
    if (frame_q.size() == len) begin
      check(field(0, 5) == n, {req, " count field"}, field(0, 5), n);
      for (int i = 0; i < n; i++)
        check(field(5 + 13 * i, 13) == hits_q[i], {req, " timestamp"}, field(5 + 13 * i, 13), hits_q[i]);
      check(int'(frame_q[len - 1]) == eo, {req, " overflow bit"}, frame_q[len - 1], eo);
    end
  endtask

  task automatic t_reset;
    check({comp_en_o, ser_valid_o, ser_o, overflow_o, abort_o} == 5'b0, "R1 in reset", 0, 0);
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    check({comp_en_o, ser_valid_o, ser_o, overflow_o, abort_o} == 5'b0, "R1 after reset",
          {comp_en_o, ser_valid_o, ser_o, overflow_o, abort_o}, 0);
  endtask

  task automatic t_basic;
    // R3: stray hits before the window must not be stored
    repeat (3) begin
      @(negedge clk) begin xing_i = 1; hit_i = 1; end
    end
    @(negedge clk) begin xing_i = 0; hit_i = 0; end
    set_hits('{0, 1, 2, 777, 2500, 4999});
    run_train(0);
    check(ser_valid_o == 1'b1, "R5 frame starts after last crossing", ser_valid_o, 1);
    collect(1'b1);  // R8 strobes/hits during readout
    verify_frame("R3 R8 basic");
    check(overflow_o == 1'b0, "R4 no overflow", overflow_o, 0);
  endtask

  task automatic t_gap;
    set_hits('{3, 4, 100, 4998});
    run_train(1);
    collect(1'b0);
    verify_frame("R9 strobe gaps");
  endtask

  task automatic t_empty;
    set_hits('{});
    run_train(0);
    collect(1'b0);
    verify_frame("R5 empty frame");
  endtask

  task automatic t_overflow;
    int h[$];
    for (int i = 0; i < 20; i++) h.push_back(10 + 37 * i);
    set_hits(h);
    run_train(0);
    check(overflow_o == 1'b1, "R4 overflow set", overflow_o, 1);
    collect(1'b0);
    verify_frame("R4 overflow");
    check(overflow_o == 1'b1, "R4 overflow sticky", overflow_o, 1);
    @(negedge clk) train_start_i = 1;
    @(negedge clk) train_start_i = 0;
    check(overflow_o == 1'b0, "R4 overflow cleared", overflow_o, 0);
    set_hits('{});
    for (int k = 0; k < NX; k++) begin
      xing_i = 1; @(negedge clk);
    end
    xing_i = 0;
    collect(1'b0);
  endtask

  task automatic t_mask;
    int h[$];
    bit seen = 0;
    for (int i = 0; i < 20; i++) h.push_back(i);
    @(negedge clk) begin mask_we_i = 1; mask_i = 1; end
    @(negedge clk) begin mask_we_i = 0; mask_i = 0; end
    set_hits(h);
    run_train(0);
    repeat (300) begin
      if (ser_valid_o) seen = 1;
      @(negedge clk);
    end
    check(seen == 1'b0, "R6 masked sends no frame", seen, 0);
    check(overflow_o == 1'b0, "R6 masked no overflow", overflow_o, 0);
    @(negedge clk) mask_we_i = 1;
    @(negedge clk) mask_we_i = 0;
  endtask

  task automatic t_abort;
    set_hits('{5, 6, 7, 8, 9, 10, 11, 12});
    run_train(0);
    repeat (20) @(negedge clk);
    check(ser_valid_o == 1'b1, "R7 readout in progress", ser_valid_o, 1);
    set_hits('{7, 4999});
    run_train(0);  // its start cuts the running frame
    check(abort_o == 1'b1, "R7 abort flagged", abort_o, 1);
    collect(1'b0);
    verify_frame("R7 post-abort frame");
    check(abort_o == 1'b1, "R7 abort held", abort_o, 1);
    set_hits('{});
    run_train(0);
    check(abort_o == 1'b0, "R7 abort cleared by clean start", abort_o, 0);
    collect(1'b0);
    verify_frame("R7 clean frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_gap();
    t_empty();
    t_overflow();
    t_mask();
    t_abort();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule